// File: doc/BRIEF.md
# Console Memory-Map Address Decoder

This block sits between an 8-bit CPU with a 16-bit address space and the memories and register banks behind it. It decodes each CPU read or write into a single one-hot target select and a write strobe. It also produces a target-local address, in which accesses to the mirror window are remapped onto work RAM. Read data from the chosen target is multiplexed back to the CPU combinationally.

The decoder also enforces access rules that depend on the display controller's current mode. Video memory is locked while pixels are being drawn. Sprite attribute memory is open only during the two blanking modes. A small dead window never accepts an access. I/O offsets that are not implemented read back as all ones.

The only state in the block is a start-up overlay flag. While it is set, reads of the lowest 256 bytes are served from a boot ROM instead of the cartridge. Writing any nonzero byte to one fixed I/O address clears the flag, and it stays cleared until reset.

Top module: `mmap_decoder`

## Requirements
- R1: Addresses 0x0000-0x7FFF (when the overlay does not apply) and 0xA000-0xBFFF select the cartridge target (tgt_sel bit 1) for reads and writes, with tgt_addr equal to cpu_addr.
- R2: After reset the overlay is on. While it is on, reads of 0x0000-0x00FF select the boot target (bit 0). Writes to that range still select the cartridge.
- R3: A write of a nonzero byte to 0xFF50 turns the overlay off from the next clock edge until reset. A write of zero there leaves it on. 0xFF50 is itself an unimplemented I/O offset.
- R4: 0xC000-0xCFFF selects work-RAM bank 0 (bit 3) and 0xD000-0xDFFF selects bank 1 (bit 4).
- R5: 0xE000-0xFDFF is a mirror. tgt_addr becomes 0xC000 plus (cpu_addr AND 0x1FFF), and the bank is chosen from that remapped address exactly as in R4.
- R6: disp_mode encodes 0 = horizontal blank, 1 = vertical blank, 2 = sprite search, 3 = drawing. Video RAM 0x8000-0x9FFF (bit 2) is selected in modes 0-2. In mode 3 nothing is selected and reads return 0xFF.
- R7: Sprite attribute RAM 0xFE00-0xFE9F (bit 5) is selected only in modes 0 and 1. Otherwise nothing is selected and reads return 0xFF.
- R8: 0xFEA0-0xFEFF never selects a target. Reads there return 0x00 in modes 0 and 1 and 0xFF in modes 2 and 3.
- R9: 0xFF00-0xFF7F selects the I/O target (bit 6) only for implemented offsets: 0x00-0x02, 0x04-0x07, 0x0F, 0x10-0x14, 0x16-0x1E, 0x20-0x26, 0x30-0x3F and 0x40-0x4B. Other offsets select nothing and read 0xFF.
- R10: 0xFF80-0xFFFE selects high RAM (bit 7) and 0xFFFF selects the interrupt-enable register (bit 8).
- R11: tgt_sel has at most one bit set, and only while cpu_rd or cpu_wr is high. tgt_we equals cpu_wr while any select is set. On a read that selects a target, cpu_rdata is that target's read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | CPU address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_wdata | input | 8 | CPU write data |
| disp_mode | input | 2 | Display controller mode |
| boot_rdata | input | 8 | Boot ROM read data |
| cart_rdata | input | 8 | Cartridge read data |
| vram_rdata | input | 8 | Video RAM read data |
| wram0_rdata | input | 8 | Work RAM bank 0 read data |
| wram1_rdata | input | 8 | Work RAM bank 1 read data |
| oam_rdata | input | 8 | Sprite attribute RAM read data |
| io_rdata | input | 8 | I/O register read data |
| hram_rdata | input | 8 | High RAM read data |
| ie_rdata | input | 8 | Interrupt-enable register read data |
| tgt_sel | output | 9 | One-hot target select |
| tgt_we | output | 1 | Write strobe to the selected target |
| tgt_addr | output | 16 | Target-local address (mirror remapped) |
| tgt_wdata | output | 8 | Write data to targets |
| cpu_rdata | output | 8 | Read data returned to the CPU |

## Verification
The assertions assume that cpu_rd and cpu_wr are never high in the same cycle, and that disp_mode is stable while an access is presented. The stimulus holds each address for a whole nanosecond step with at most one request line raised. Write sweeps use zero write data, so the overlay flag changes only in the dedicated R3 sequence. The full-space read sweeps rely on the flag staying constant between clock edges.

// File: rtl/mmap_pkg.sv
package mmap_pkg;
    localparam int ADDR_W = 16;
    localparam int NTGT   = 9;

    typedef enum logic [3:0] {
        TGT_BOOT  = 4'd0,
        TGT_CART  = 4'd1,
        TGT_VRAM  = 4'd2,
        TGT_WRAM0 = 4'd3,
        TGT_WRAM1 = 4'd4,
        TGT_OAM   = 4'd5,
        TGT_IO    = 4'd6,
        TGT_HRAM  = 4'd7,
        TGT_IE    = 4'd8,
        TGT_NONE  = 4'd15
    } tgt_e;

    typedef enum logic [1:0] {
        MODE_HBLANK = 2'd0,
        MODE_VBLANK = 2'd1,
        MODE_SEARCH = 2'd2,
        MODE_DRAW   = 2'd3
    } disp_mode_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [ADDR_W-1:0] loc;
        logic              vram;
        logic              oam;
        logic              dead;
        logic              io;
    } region_t;

    typedef struct packed {
        logic boot_en;
    } ctl_t;
endpackage

// File: rtl/mmap_region_decode.sv
module mmap_region_decode
    import mmap_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              boot_en,
    input  logic              is_wr,
    output region_t           region
);
    localparam logic [ADDR_W-1:0] MIRROR_MASK = 16'h1FFF;
    localparam logic [ADDR_W-1:0] WRAM_BASE   = 16'hC000;

    logic [ADDR_W-1:0] mirrored;

    always_comb begin
        mirrored = WRAM_BASE | (addr & MIRROR_MASK);
        region   = '{tgt: TGT_NONE, loc: addr, vram: 1'b0, oam: 1'b0, dead: 1'b0, io: 1'b0};
        if (!addr[15]) begin
            region.tgt = (boot_en && !is_wr && addr[15:8] == 8'h00) ? TGT_BOOT : TGT_CART;
        end else if (addr[15:13] == 3'b100) begin
            region.tgt  = TGT_VRAM;
            region.vram = 1'b1;
        end else if (addr[15:13] == 3'b101) begin
            region.tgt = TGT_CART;
        end else if (addr[15:12] == 4'hC) begin
            region.tgt = TGT_WRAM0;
        end else if (addr[15:12] == 4'hD) begin
            region.tgt = TGT_WRAM1;
        end else if (addr < 16'hFE00) begin
            region.loc = mirrored;
            region.tgt = mirrored[12] ? TGT_WRAM1 : TGT_WRAM0;
        end else if (addr < 16'hFEA0) begin
            region.tgt = TGT_OAM;
            region.oam = 1'b1;
        end else if (addr[15:8] == 8'hFE) begin
            region.dead = 1'b1;
        end else if (!addr[7]) begin
            region.tgt = TGT_IO;
            region.io  = 1'b1;
        end else if (addr[7:0] != 8'hFF) begin
            region.tgt = TGT_HRAM;
        end else begin
            region.tgt = TGT_IE;
        end
    end
endmodule

// File: rtl/mmap_access_gate.sv
module mmap_access_gate
    import mmap_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  region_t           region,
    input  disp_mode_e        mode,
    input  logic              io_impl,
    output logic              allowed,
    output logic [DATA_W-1:0] fill
);
    logic blanking;

    always_comb begin
        blanking = (mode == MODE_HBLANK) || (mode == MODE_VBLANK);
        allowed  = (region.tgt != TGT_NONE);
        fill     = '1;
        if (region.vram && mode == MODE_DRAW) allowed = 1'b0;
        if (region.oam && !blanking)          allowed = 1'b0;
        if (region.io && !io_impl)            allowed = 1'b0;
        if (region.dead) begin
            allowed = 1'b0;
            fill    = blanking ? '0 : '1;
        end
    end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
    import mmap_pkg::*;
#(
    parameter int           DATA_W       = 8,
    parameter logic [127:0] IO_IMPL_MASK = 128'h0000_0000_0000_0FFF_FFFF_007F_7FDF_80F7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              cpu_rd,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic [1:0]        disp_mode,
    input  logic [DATA_W-1:0] boot_rdata,
    input  logic [DATA_W-1:0] cart_rdata,
    input  logic [DATA_W-1:0] vram_rdata,
    input  logic [DATA_W-1:0] wram0_rdata,
    input  logic [DATA_W-1:0] wram1_rdata,
    input  logic [DATA_W-1:0] oam_rdata,
    input  logic [DATA_W-1:0] io_rdata,
    input  logic [DATA_W-1:0] hram_rdata,
    input  logic [DATA_W-1:0] ie_rdata,
    output logic [8:0]        tgt_sel,
    output logic              tgt_we,
    output logic [15:0]       tgt_addr,
    output logic [DATA_W-1:0] tgt_wdata,
    output logic [DATA_W-1:0] cpu_rdata
);
    localparam logic [15:0] BOOT_OFF_ADDR = 16'hFF50;

    ctl_t              ctl_d, ctl_q;
    region_t           region;
    logic              allowed;
    logic [DATA_W-1:0] fill;
    logic [DATA_W-1:0] rd_bus [NTGT];
    logic [DATA_W-1:0] picked;
    logic              access;

    mmap_region_decode u_decode (
        .addr    (cpu_addr),
        .boot_en (ctl_q.boot_en),
        .is_wr   (cpu_wr),
        .region  (region)
    );

    mmap_access_gate #(.DATA_W(DATA_W)) u_gate (
        .region  (region),
        .mode    (disp_mode_e'(disp_mode)),
        .io_impl (IO_IMPL_MASK[cpu_addr[6:0]]),
        .allowed (allowed),
        .fill    (fill)
    );

    assign access = cpu_rd | cpu_wr;

    genvar g;
    generate
        for (g = 0; g < NTGT; g++) begin : g_sel
            assign tgt_sel[g] = access && allowed && (region.tgt == tgt_e'(g));
        end
    endgenerate

    assign rd_bus[TGT_BOOT]  = boot_rdata;
    assign rd_bus[TGT_CART]  = cart_rdata;
    assign rd_bus[TGT_VRAM]  = vram_rdata;
    assign rd_bus[TGT_WRAM0] = wram0_rdata;
    assign rd_bus[TGT_WRAM1] = wram1_rdata;
    assign rd_bus[TGT_OAM]   = oam_rdata;
    assign rd_bus[TGT_IO]    = io_rdata;
    assign rd_bus[TGT_HRAM]  = hram_rdata;
    assign rd_bus[TGT_IE]    = ie_rdata;

    always_comb begin
        picked = fill;
        for (int i = 0; i < NTGT; i++) begin
            if (region.tgt == tgt_e'(i)) picked = rd_bus[i];
        end
    end

    assign cpu_rdata = allowed ? picked : fill;
    assign tgt_we    = cpu_wr && allowed;
    assign tgt_addr  = region.loc;
    assign tgt_wdata = cpu_wdata;

    always_comb begin
        ctl_d = ctl_q;
        if (cpu_wr && cpu_addr == BOOT_OFF_ADDR && cpu_wdata != '0) ctl_d.boot_en = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{boot_en: 1'b1};
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [7:0]  cpu_wdata,
    input logic [1:0]  disp_mode,
    input logic [8:0]  tgt_sel,
    input logic        tgt_we,
    input logic [15:0] tgt_addr
);
    a_r11_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tgt_sel));

    a_r11_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_rd && !cpu_wr) |-> (tgt_sel == 9'd0 && !tgt_we));

    a_r11_we: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_we |-> (cpu_wr && tgt_sel != 9'd0));

    a_r6_vram_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr[15:13] == 3'b100 && disp_mode == 2'd3) |-> tgt_sel == 9'd0);

    a_r7_oam_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'hFE00 && cpu_addr < 16'hFEA0 && disp_mode[1]) |-> tgt_sel == 9'd0);

    a_r8_dead: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'hFEA0 && cpu_addr < 16'hFF00) |-> tgt_sel == 9'd0);

    a_r5_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr >= 16'hE000 && cpu_addr < 16'hFE00 && tgt_sel != 9'd0)
            |-> tgt_addr == {3'b110, cpu_addr[12:0]});

    a_r3_boot_off: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_wr && cpu_addr == 16'hFF50 && cpu_wdata != 8'd0) |=> !tgt_sel[0]);
endmodule

bind mmap_decoder mmap_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_rd    (cpu_rd),
    .cpu_wr    (cpu_wr),
    .cpu_wdata (cpu_wdata),
    .disp_mode (disp_mode),
    .tgt_sel   (tgt_sel),
    .tgt_we    (tgt_we),
    .tgt_addr  (tgt_addr)
);

// File: tb/mmap_decoder_test.sv
module mmap_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = 16'd0;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_wdata = 8'd0;
    logic [1:0]  disp_mode = 2'd0;
    logic [7:0]  boot_rdata, cart_rdata, vram_rdata, wram0_rdata, wram1_rdata;
    logic [7:0]  oam_rdata, io_rdata, hram_rdata, ie_rdata;
    logic [8:0]  tgt_sel;
    logic        tgt_we;
    logic [15:0] tgt_addr;
    logic [7:0]  tgt_wdata;
    logic [7:0]  cpu_rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    function automatic logic [7:0] key(input int t);
        return 8'((t + 1) * 17);
    endfunction

    assign boot_rdata  = tgt_addr[7:0] ^ key(0);
    assign cart_rdata  = tgt_addr[7:0] ^ key(1);
    assign vram_rdata  = tgt_addr[7:0] ^ key(2);
    assign wram0_rdata = tgt_addr[7:0] ^ key(3);
    assign wram1_rdata = tgt_addr[7:0] ^ key(4);
    assign oam_rdata   = tgt_addr[7:0] ^ key(5);
    assign io_rdata    = tgt_addr[7:0] ^ key(6);
    assign hram_rdata  = tgt_addr[7:0] ^ key(7);
    assign ie_rdata    = tgt_addr[7:0] ^ key(8);

    mmap_decoder uut (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
        .cpu_wdata(cpu_wdata), .disp_mode(disp_mode),
        .boot_rdata(boot_rdata), .cart_rdata(cart_rdata), .vram_rdata(vram_rdata),
        .wram0_rdata(wram0_rdata), .wram1_rdata(wram1_rdata), .oam_rdata(oam_rdata),
        .io_rdata(io_rdata), .hram_rdata(hram_rdata), .ie_rdata(ie_rdata),
        .tgt_sel(tgt_sel), .tgt_we(tgt_we), .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata),
        .cpu_rdata(cpu_rdata)
    );

    function automatic bit io_impl(input int o);
        return (o <= 'h02) || (o >= 'h04 && o <= 'h07) || (o == 'h0F) ||
               (o >= 'h10 && o <= 'h14) || (o >= 'h16 && o <= 'h1E) ||
               (o >= 'h20 && o <= 'h26) || (o >= 'h30 && o <= 'h4B);
    endfunction

    function automatic int req_of(input int a);
        if (a < 'h100)  return 2;
        if (a < 'h8000) return 1;
        if (a < 'hA000) return 6;
        if (a < 'hC000) return 1;
        if (a < 'hE000) return 4;
        if (a < 'hFE00) return 5;
        if (a < 'hFEA0) return 7;
        if (a < 'hFF00) return 8;
        if (a < 'hFF80) return 9;
        return 10;
    endfunction

    task automatic expect_at(input int a, input int md, input bit rd, input bit wr, input bit boot);
        int t;
        logic [15:0] la;
        logic [7:0]  fillv;
        logic [8:0]  esel;
        logic [7:0]  erd;
        bit ok;
        t = -1; la = 16'(a); fillv = 8'hFF;
        if (a < 'h8000)      t = (boot && !wr && a < 'h100) ? 0 : 1;
        else if (a < 'hA000) t = (md == 3) ? -1 : 2;
        else if (a < 'hC000) t = 1;
        else if (a < 'hD000) t = 3;
        else if (a < 'hE000) t = 4;
        else if (a < 'hFE00) begin
            la = 16'('hC000 + (a - 'hE000));
            t  = (la < 16'hD000) ? 3 : 4;
        end
        else if (a < 'hFEA0) t = (md < 2) ? 5 : -1;
        else if (a < 'hFF00) fillv = (md < 2) ? 8'h00 : 8'hFF;
        else if (a < 'hFF80) t = io_impl(a - 'hFF00) ? 6 : -1;
        else if (a < 'hFFFF) t = 7;
        else                 t = 8;
        esel = (t >= 0 && (rd || wr)) ? (9'd1 << t) : 9'd0;
        erd  = (t >= 0) ? (la[7:0] ^ key(t)) : fillv;
        ok = (tgt_sel === esel) && (tgt_we === (wr && esel != 0));
        if (esel != 0) ok = ok && (tgt_addr === la);
        if (rd)        ok = ok && (cpu_rdata === erd);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL R%0d/R11 addr=%h mode=%0d rd=%0b wr=%0b: sel=%b we=%b taddr=%h rdata=%h expected sel=%b we=%b taddr=%h rdata=%h",
                     req_of(a), a, md, rd, wr, tgt_sel, tgt_we, tgt_addr, cpu_rdata,
                     esel, (wr && esel != 0), la, erd);
        end
    endtask

    task automatic sweep(input int md, input bit rd, input bit wr, input bit boot);
        disp_mode = 2'(md); cpu_rd = rd; cpu_wr = wr; cpu_wdata = 8'h00;
        for (int a = 0; a < 65536; a++) begin
            cpu_addr = 16'(a);
            #1;
            expect_at(a, md, rd, wr, boot);
        end
        cpu_rd = 1'b0; cpu_wr = 1'b0;
    endtask

    task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = 1'b1;
        @(negedge clk);
        cpu_wr = 1'b0; cpu_wdata = 8'h00;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state, overlay on
        cpu_addr = 16'h0010; cpu_rd = 1'b1; #1;
        expect_at('h0010, 0, 1, 0, 1);
        // R11: idle produces no select
        cpu_rd = 1'b0; #1;
        expect_at('h0010, 0, 0, 0, 1);
        // R1 R2 R4..R10: full read sweeps in every mode, overlay on
        for (int m = 0; m < 4; m++) sweep(m, 1, 0, 1);
        // R2 R6 R7 R8 R9 R11: write sweeps (zero data keeps overlay on)
        sweep(0, 0, 1, 1);
        sweep(3, 0, 1, 1);
        // R3: zero write keeps overlay
        cpu_write(16'hFF50, 8'h00);
        cpu_addr = 16'h0000; cpu_rd = 1'b1; #1;
        expect_at('h0000, 3, 1, 0, 1);
        cpu_rd = 1'b0;
        // R3: nonzero write clears overlay
        cpu_write(16'hFF50, 8'h5A);
        cpu_addr = 16'h00FF; cpu_rd = 1'b1; #1;
        expect_at('h00FF, 3, 1, 0, 0);
        cpu_rd = 1'b0;
        // R3: clearing is sticky even after writing zero
        cpu_write(16'hFF50, 8'h00);
        sweep(1, 1, 0, 0);
        // R3: reset brings overlay back
        rst_n = 1'b0; @(negedge clk); rst_n = 1'b1; @(negedge clk);
        cpu_addr = 16'h0042; cpu_rd = 1'b1; #1;
        expect_at('h0042, 2, 1, 0, 1);
        cpu_rd = 1'b0;
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule